// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block keeps the program counter of a small 16-bit-opcode processor and a hardware return stack eight entries deep. Each cycle on which `step` is high, it takes the fetched opcode and decodes only the control-flow instructions. It reads the zero, carry and negative flags and a 16-bit page register, all supplied by the datapath, and from these it works out the next PC. Fetch memory, the ALU and the data registers are outside the block.

Jumps can be unconditional or depend on one flag. A jump target is either short or long. A short target keeps the upper PC bits and replaces the low byte. A long target is built from the page register and the low byte. A taken jump can also act as a call and save its return address on the stack. The stack is a plain shift register: a push drops the deepest entry, and a pop moves a zero into the deepest slot. Skip instructions move past one instruction when a flag matches. The halt instruction stops the sequencer, and so does any opcode the processor does not define. The PC, the halt state and the whole stack are brought out so they can be observed.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low, the PC is 0, `halted` is 0 and all eight stack slots are 0.
- R2: A cycle with `step` low changes nothing: the PC, the stack and `halted` keep their values.
- R3: A recognised opcode that is not control flow advances the PC by one and leaves the stack unchanged. Such opcodes are 0x0000 (no-op), 0x1C00 and 0x4000 (exact matches); any value with `op & 0xF800` in {0x4800, 0x5000, 0x8000, 0x8800, 0x9000, 0xA800}; any value with `op & 0xFB00` in {0x5900, 0x5A00, 0x6000, 0x6100, 0x6300, 0x6800, 0x6900, 0x6A00, 0x9800, 0xC800, 0xD000, 0xD800, 0xE800, 0xE900, 0xEA00}; 0x7000 (exact match); and any value with `op & 0xFF00` in {0x7C00, 0x7D00, 0xE000, 0xF000}.
- R4: A jump is any opcode with `op & 0xDD00` equal to one of four values. 0x0800 is always taken. 0x0C00 is taken when zero is set, 0x1000 when carry is set, and 0x1400 when negative is set. A jump that is not taken advances the PC by one.
- R5: For a taken jump, bit 9 of the opcode selects the target. When bit 9 is 1, the target is {page, op[7:0]}. When bit 9 is 0, the target is {(PC+1)[23:8], op[7:0]}.
- R6: A taken jump with opcode bit 13 set is a call. It pushes PC+1 into slot 0, moves every other entry one slot deeper, and loses the entry that was in slot 7.
- R7: Opcode 0x3C00 is a return. It loads the PC from slot 0, moves every other entry one slot toward the top, and writes zero into slot 7.
- R8: The skip opcodes are 0x2500/0x2501, 0x2600/0x2601 and 0x2700/0x2701. They test carry, zero and negative respectively. When the tested flag equals opcode bit 0, the PC advances by two; otherwise it advances by one.
- R9: Opcode 0xFC00 sets `halted`, and the PC stays unchanged.
- R10: Any opcode that matches none of the patterns in R3, R4, R7, R8 or R9 sets `halted` and leaves the PC unchanged.
- R11: Once `halted` is 1, the PC, the stack and `halted` stay frozen until reset, whatever is applied to `step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Executes `opcode` in this cycle |
| opcode | input | 16 | Fetched instruction word |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| page | input | 16 | Page register used by long jump targets |
| pc | output | 24 | Program counter |
| halted | output | 1 | Sequencer is stopped |
| stack_flat | output | 192 | Stack contents; slot i occupies bits [24*i+23 : 24*i], with slot 0 as the top |

## Verification
Random opcode streams bias toward jumps, calls, skips and returns, with random flags and page values. Each jump is tried with its condition both met and not met, which separates the four condition codes. Random bits 9 and 13 separate short targets from long ones and plain jumps from calls. Directed runs cover three cases: nine nested calls, which must lose the oldest return address; nine returns, which must bring zeros up from the bottom; and halts caused both by 0xFC00 and by an undefined word, with further steps applied after the halt.

// File: rtl/prog_seq.sv
`timescale 1ns/1ps
module prog_seq #(
  parameter int PCW   = 24,
  parameter int DEPTH = 8,
  parameter int PGW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [15:0]          opcode,
  input  logic                 flag_z,
  input  logic                 flag_c,
  input  logic                 flag_n,
  input  logic [PGW-1:0]       page,
  output logic [PCW-1:0]       pc,
  output logic                 halted,
  output logic [DEPTH*PCW-1:0] stack_flat
);

  logic [PCW-1:0] stk [DEPTH];

  function automatic logic known_op(input logic [15:0] o);
    logic [15:0] m8, mb, mf;
    m8 = o & 16'hF800;
    mb = o & 16'hFB00;
    mf = o & 16'hFF00;
    return (o == 16'h0000) || (o == 16'h1C00) || (o == 16'h3C00) ||
           (o == 16'h4000) || (o == 16'h7000) || (o == 16'hFC00) ||
           ((o & 16'hDD00) inside {16'h0800, 16'h0C00, 16'h1000, 16'h1400}) ||
           ((o & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) ||
           (m8 inside {16'h4800, 16'h5000, 16'h8000, 16'h8800, 16'h9000, 16'hA800}) ||
           (mb inside {16'h5900, 16'h5A00, 16'h6000, 16'h6100, 16'h6300, 16'h6800,
                       16'h6900, 16'h6A00, 16'h9800, 16'hC800, 16'hD000, 16'hD800,
                       16'hE800, 16'hE900, 16'hEA00}) ||
           (mf inside {16'h7C00, 16'h7D00, 16'hE000, 16'hF000});
  endfunction

  logic [PCW-1:0] pc_inc, target, pc_nxt;
  logic           take, skip_hit, is_ret, stop, do_push, do_pull, sk_flag;

  assign pc_inc = pc + PCW'(1);

  always_comb begin
    unique case (opcode & 16'hDD00)
      16'h0800: take = 1'b1;
      16'h0C00: take = flag_z;
      16'h1000: take = flag_c;
      16'h1400: take = flag_n;
      default:  take = 1'b0;
    endcase
  end

  always_comb begin
    unique case (opcode[9:8])
      2'b01:   sk_flag = flag_c;
      2'b10:   sk_flag = flag_z;
      default: sk_flag = flag_n;
    endcase
  end

  assign skip_hit = ((opcode & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) &&
                    (sk_flag == opcode[0]);
  assign is_ret   = opcode == 16'h3C00;
  assign stop     = (opcode == 16'hFC00) || !known_op(opcode);
  assign do_push  = take && opcode[13];
  assign do_pull  = is_ret;

  assign target = opcode[9] ? PCW'({page, opcode[7:0]})
                            : {pc_inc[PCW-1:8], opcode[7:0]};

  assign pc_nxt = do_pull  ? stk[0] :
                  take     ? target :
                  skip_hit ? pc + PCW'(2) : pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (step && !halted) begin
      if (stop) halted <= 1'b1;
      else      pc     <= pc_nxt;
      if (!stop && do_push) begin
        stk[0] <= pc_inc;
        for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      end else if (!stop && do_pull) begin
        for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
        stk[DEPTH-1] <= '0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign stack_flat[g*PCW +: PCW] = stk[g];
  end

endmodule

// File: rtl/prog_seq_props.sv
`timescale 1ns/1ps
module prog_seq_props #(
  parameter int PCW   = 24,
  parameter int DEPTH = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 step,
  input logic [15:0]          opcode,
  input logic                 flag_z,
  input logic [PCW-1:0]       pc,
  input logic                 halted,
  input logic [DEPTH*PCW-1:0] stack_flat
);

  logic live;
  assign live = step && !halted;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(stack_flat) && $stable(halted));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(stack_flat));

  p_call_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (opcode & 16'hDD00) == 16'h0800 && opcode[13])
      |=> stack_flat[PCW-1:0] == PCW'($past(pc) + 1));

  p_return_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opcode == 16'h3C00)
      |=> pc == $past(stack_flat[PCW-1:0]) && stack_flat[DEPTH*PCW-1 -: PCW] == '0);

  p_skip_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (opcode & 16'hFFFE) == 16'h2600 && flag_z == opcode[0])
      |=> pc == PCW'($past(pc) + 2));

  p_halt_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opcode == 16'hFC00) |=> halted && $stable(pc));

endmodule

bind prog_seq prog_seq_props #(.PCW(PCW), .DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .step(step), .opcode(opcode), .flag_z(flag_z),
  .pc(pc), .halted(halted), .stack_flat(stack_flat)
);

// File: tb/test_prog_seq.sv
`timescale 1ns/1ps
module test_prog_seq;
  localparam int PCW = 24, DEPTH = 8;

  logic clk = 0, rst_n = 0, step = 0, fz = 0, fc = 0, fn = 0;
  logic [15:0] op = 0, pg = 0;
  logic [PCW-1:0] pc;
  logic halted;
  logic [DEPTH*PCW-1:0] sf;

  int checks = 0, fails = 0;
  logic [PCW-1:0] m_pc;
  logic [PCW-1:0] m_stk [DEPTH];
  logic m_halt;

  always #10 clk = ~clk;

  prog_seq i_prog_seq (.clk(clk), .rst_n(rst_n), .step(step), .opcode(op),
    .flag_z(fz), .flag_c(fc), .flag_n(fn), .page(pg),
    .pc(pc), .halted(halted), .stack_flat(sf));

  function automatic logic defined(input logic [15:0] o);
    if (o inside {16'h0000, 16'h1C00, 16'h3C00, 16'h4000, 16'h7000, 16'hFC00}) return 1;
    if ((o & 16'hDD00) inside {16'h0800, 16'h0C00, 16'h1000, 16'h1400}) return 1;
    if ((o & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) return 1;
    if ((o & 16'hF800) inside {16'h4800, 16'h5000, 16'h8000, 16'h8800, 16'h9000, 16'hA800}) return 1;
    if ((o & 16'hFB00) inside {16'h5900, 16'h5A00, 16'h6000, 16'h6100, 16'h6300, 16'h6800,
        16'h6900, 16'h6A00, 16'h9800, 16'hC800, 16'hD000, 16'hD800, 16'hE800, 16'hE900,
        16'hEA00}) return 1;
    return (o & 16'hFF00) inside {16'h7C00, 16'h7D00, 16'hE000, 16'hF000};
  endfunction

  function automatic string tag_of(input logic [15:0] o);
    if (m_halt) return "R11";
    if ((o & 16'hDD00) inside {16'h0800, 16'h0C00, 16'h1000, 16'h1400}) return "R4/R5/R6";
    if ((o & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) return "R8";
    if (o == 16'h3C00) return "R7";
    if (o == 16'hFC00) return "R9";
    if (!defined(o)) return "R10";
    return "R3";
  endfunction

  task automatic model_reset();
    m_pc = '0; m_halt = 0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
  endtask

  task automatic model_step(input logic [15:0] o);
    logic [PCW-1:0] nx;
    logic t, f;
    if (m_halt) return;
    if (o == 16'hFC00 || !defined(o)) begin m_halt = 1; return; end
    nx = m_pc + 1;
    t = ((o & 16'hDD00) == 16'h0800) || ((o & 16'hDD00) == 16'h0C00 && fz) ||
        ((o & 16'hDD00) == 16'h1000 && fc) || ((o & 16'hDD00) == 16'h1400 && fn);
    if (t) begin
      if (o[13]) begin
        for (int i = DEPTH-1; i > 0; i--) m_stk[i] = m_stk[i-1];
        m_stk[0] = m_pc + 1;
      end
      nx = o[9] ? {pg, o[7:0]} : {nx[PCW-1:8], o[7:0]};
    end else if ((o & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) begin
      f = (o[9:8] == 2'b01) ? fc : (o[9:8] == 2'b10) ? fz : fn;
      if (f == o[0]) nx = m_pc + 2;
    end else if (o == 16'h3C00) begin
      nx = m_stk[0];
      for (int i = 0; i < DEPTH-1; i++) m_stk[i] = m_stk[i+1];
      m_stk[DEPTH-1] = '0;
    end
    m_pc = nx;
  endtask

  task automatic compare(input string tag);
    logic [DEPTH*PCW-1:0] ef;
    for (int i = 0; i < DEPTH; i++) ef[i*PCW +: PCW] = m_stk[i];
    checks++;
    if (pc !== m_pc || halted !== m_halt || sf !== ef) begin
      fails++;
      $display("FAIL %s: pc=%h halted=%b stack=%h expected pc=%h halted=%b stack=%h",
               tag, pc, halted, sf, m_pc, m_halt, ef);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step = 0;
    model_reset();
    #5 compare("R1");
    @(negedge clk); rst_n = 1;
  endtask

  task automatic exec(input logic [15:0] o, input logic s = 1);
    string tg;
    @(negedge clk);
    op = o; step = s;
    tg = s ? tag_of(o) : "R2";
    @(posedge clk);
    if (s) model_step(o);
    #5 compare(tg);
  endtask

  function automatic logic [15:0] rnd_op();
    int r;
    logic [15:0] base [4] = '{16'h0800, 16'h0C00, 16'h1000, 16'h1400};
    r = $urandom % 16;
    if (r < 6) return base[$urandom % 4] | ($urandom % 2 ? 16'h2000 : 16'h0) |
                      ($urandom % 2 ? 16'h0200 : 16'h0) | 16'($urandom % 256);
    if (r < 8) return 16'h2500 + 16'(($urandom % 3) << 8) + 16'($urandom % 2);
    if (r < 10) return 16'h3C00;
    if (r == 10) return 16'h0000;
    if (r == 11) return 16'h8000 | 16'($urandom % 2048);
    if (r == 12) return 16'hE000 | 16'($urandom % 256);
    if (r == 13) return 16'h1C00;
    if (r == 14 && $urandom % 6 == 0) return ($urandom % 2) ? 16'hFC00 : 16'h1800;
    return 16'h6000 | 16'($urandom % 256);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    do_reset();
    exec(16'h0000);                       // R3 no-op
    exec(16'h3C00, 0);                    // R2 idle cycle
    pg = 16'h12AB;
    exec(16'h2A34);                       // R5 R6 long call
    exec(16'h0877);                       // R5 short jump
    fz = 0; exec(16'h0C10);               // R4 not taken
    fc = 1; exec(16'h1020);               // R4 carry taken
    fz = 1; exec(16'h2601);               // R8 skip on zero
    // R6: nine nested calls drop the oldest return address
    for (int k = 0; k < 9; k++) begin pg = 16'(k * 3 + 1); exec(16'h2A00 | 16'(k)); end
    // R7: nine returns refill with zeros
    for (int k = 0; k < 9; k++) exec(16'h3C00);
    exec(16'hFC00);                       // R9
    exec(16'h0800); exec(16'h3C00);       // R11 frozen
    do_reset();
    exec(16'h1800);                       // R10 undefined
    exec(16'h0000);                       // R11
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      for (int k = 0; k < 120; k++) begin
        fz = 1'($urandom); fc = 1'($urandom); fn = 1'($urandom);
        pg = 16'($urandom);
        exec(rnd_op(), ($urandom % 8) != 0);
      end
    end
    finish_run();
  end
endmodule